// File: doc/BRIEF.md
# Nibble Parallel I/O Channels

This block holds four 4-bit channel registers that drive a set of open-drain common pins, one nibble per channel. A 2-bit operand chooses the channel for each I/O instruction. An output instruction copies a nibble from either the accumulator or the B register into the chosen channel register. A pattern instruction takes one byte supplied by program memory and splits it over channels 2 and 3 in one cycle. An input instruction reads the chosen channel's pin level back toward the accumulator or the B register.

The pins are open-drain. Each bit has an external-drive input, where 0 means something outside pulls the line low. During an input the channel register keeps driving, so the level read is the AND of the register bit and the external drive. Software therefore writes all ones to a channel before using it as an input. The read is captured on a separate sampling strobe later in the instruction cycle. It is held in a result register, and the destination's load enable pulses for one cycle.

Top module: `nio_channels`

## Requirements
- R1: After reset every channel register holds 4'hF (all pins released), both load enables are low and the read result is 0.
- R2: An output op (`op_kind_i` = 0) with `src_sel_i` = 0 writes `acc_i` into the channel given by `chan_sel_i`. The new value appears on that channel's `pins_o` bits (channel n on bits 4n+3..4n) after the clock edge that accepts the op.
- R3: An output op with `src_sel_i` = 1 writes `breg_i` into the selected channel instead of `acc_i`.
- R4: A pattern op (`op_kind_i` = 1) writes `pat_i[7:4]` to channel 3 and `pat_i[3:0]` to channel 2 at the same edge. Channels 0 and 1 are left unchanged.
- R5: An input op (`op_kind_i` = 2) sets a pending read for the selected channel and for the destination given by `dst_sel_i` (0 = accumulator, 1 = B). The first clock edge with `sample_i` high while a read is pending captures that channel's pin level into `rd_data_o`. In the next cycle it raises `acc_we_o` (destination 0) or `b_we_o` (destination 1) for exactly one cycle.
- R6: The captured level is the bitwise AND of the channel register and the matching `ext_i` bits, so a register bit at 0 reads 0 whatever the external drive.
- R7: `rd_data_o` keeps its value until the next capture.
- R8: `sample_i` with no read pending raises no load enable and leaves `rd_data_o` unchanged.
- R9: Op kind 3, or any op while `op_valid_i` is low, changes no channel register and starts no read.
- R10: An input op does not change any channel register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Instruction strobe |
| op_kind_i | input | 2 | 0 output, 1 pattern, 2 input, 3 reserved |
| chan_sel_i | input | 2 | Channel operand |
| src_sel_i | input | 1 | Output source: 0 accumulator, 1 B |
| dst_sel_i | input | 1 | Input destination: 0 accumulator, 1 B |
| acc_i | input | 4 | Accumulator value |
| breg_i | input | 4 | B register value |
| pat_i | input | 8 | Pattern byte from program memory |
| sample_i | input | 1 | Input sampling strobe |
| ext_i | input | 16 | External drive per pin, 0 pulls low |
| pins_o | output | 16 | Open-drain drive, 0 pulls low |
| rd_data_o | output | 4 | Captured input nibble |
| acc_we_o | output | 1 | Load accumulator with rd_data_o |
| b_we_o | output | 1 | Load B with rd_data_o |

## Verification
A corrupted channel register shows on `pins_o` in the cycle right after the faulty write. It also shows in any later read of that channel, because the wired AND keeps the register in the read path. A wrong pending flag or destination shows one cycle after the strobe edge: the load pulse is missing, goes to the wrong destination, or appears with no input op before it. A capture at the wrong time shows as `rd_data_o` changing between strobes. The bench drives the external lines away from all ones so that register masking becomes visible.

// File: rtl/nio_pkg.sv
package nio_pkg;
  typedef enum logic [1:0] {
    OP_OUT = 2'd0,
    OP_PAT = 2'd1,
    OP_IN  = 2'd2,
    OP_RSV = 2'd3
  } nio_op_e;
endpackage

// File: rtl/nio_chan_regs.sv
module nio_chan_regs #(
  parameter int CH_N   = 4,
  parameter int CH_W   = 4,
  parameter int PAT_LO = 2,
  localparam int SEL_W = $clog2(CH_N)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [SEL_W-1:0]           wr_sel_i,
  input  logic [CH_W-1:0]            wr_data_i,
  input  logic                       pat_en_i,
  input  logic [2*CH_W-1:0]          pat_data_i,
  output logic [CH_N-1:0][CH_W-1:0]  chan_o
);
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chan_o[c] <= '1;
      end else if (pat_en_i && c == PAT_LO) begin
        chan_o[c] <= pat_data_i[CH_W-1:0];
      end else if (pat_en_i && c == PAT_LO + 1) begin
        chan_o[c] <= pat_data_i[2*CH_W-1:CH_W];
      end else if (wr_en_i && wr_sel_i == SEL_W'(c)) begin
        chan_o[c] <= wr_data_i;
      end
    end
  end

  p_out_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> chan_o[$past(wr_sel_i)] == $past(wr_data_i));

  p_pattern_split_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_en_i |=> (chan_o[PAT_LO+1] == $past(pat_data_i[2*CH_W-1:CH_W]))
              && (chan_o[PAT_LO] == $past(pat_data_i[CH_W-1:0])));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i || pat_en_i) |=> $stable(chan_o));
endmodule

// File: rtl/nio_in_sampler.sv
module nio_in_sampler #(
  parameter int CH_N = 4,
  parameter int CH_W = 4,
  localparam int SEL_W = $clog2(CH_N)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      issue_i,
  input  logic [SEL_W-1:0]          issue_sel_i,
  input  logic                      issue_dst_i,
  input  logic                      sample_i,
  input  logic [CH_N-1:0][CH_W-1:0] level_i,
  output logic [CH_W-1:0]           rd_data_o,
  output logic                      acc_we_o,
  output logic                      b_we_o
);
  logic             pend_q;
  logic [SEL_W-1:0] sel_q;
  logic             dst_q;
  logic             take;

  assign take = sample_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      sel_q     <= '0;
      dst_q     <= 1'b0;
      rd_data_o <= '0;
      acc_we_o  <= 1'b0;
      b_we_o    <= 1'b0;
    end else begin
      acc_we_o <= take && !dst_q;
      b_we_o   <= take && dst_q;
      if (take) rd_data_o <= level_i[sel_q];
      // a new input op overrides a completed or stale read
      if (issue_i) begin
        pend_q <= 1'b1;
        sel_q  <= issue_sel_i;
        dst_q  <= issue_dst_i;
      end else if (take) begin
        pend_q <= 1'b0;
      end
    end
  end

  p_load_needs_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_o || b_we_o) |-> $past(sample_i));

  p_single_dest_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_we_o, b_we_o}));

  p_rd_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(rd_data_o));

  p_idle_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !pend_q) |=> !(acc_we_o || b_we_o));
endmodule

// File: rtl/nio_channels.sv
module nio_channels
  import nio_pkg::*;
#(
  parameter int CH_N = 4,
  parameter int CH_W = 4,
  localparam int SEL_W = $clog2(CH_N),
  localparam int PIN_W = CH_N * CH_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_valid_i,
  input  logic [1:0]         op_kind_i,
  input  logic [SEL_W-1:0]   chan_sel_i,
  input  logic               src_sel_i,
  input  logic               dst_sel_i,
  input  logic [CH_W-1:0]    acc_i,
  input  logic [CH_W-1:0]    breg_i,
  input  logic [2*CH_W-1:0]  pat_i,
  input  logic               sample_i,
  input  logic [PIN_W-1:0]   ext_i,
  output logic [PIN_W-1:0]   pins_o,
  output logic [CH_W-1:0]    rd_data_o,
  output logic               acc_we_o,
  output logic               b_we_o
);
  nio_op_e                   kind;
  logic                      wr_en, pat_en, in_en;
  logic [CH_W-1:0]           wr_data;
  logic [CH_N-1:0][CH_W-1:0] chan, level;

  assign kind    = nio_op_e'(op_kind_i);
  assign wr_en   = op_valid_i && kind == OP_OUT;
  assign pat_en  = op_valid_i && kind == OP_PAT;
  assign in_en   = op_valid_i && kind == OP_IN;
  assign wr_data = src_sel_i ? breg_i : acc_i;

  nio_chan_regs #(.CH_N(CH_N), .CH_W(CH_W), .PAT_LO(2)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_sel_i   (chan_sel_i),
    .wr_data_i  (wr_data),
    .pat_en_i   (pat_en),
    .pat_data_i (pat_i),
    .chan_o     (chan)
  );

  // register keeps driving during a read: wired-AND with outside drive
  for (genvar c = 0; c < CH_N; c++) begin : g_lvl
    assign pins_o[c*CH_W +: CH_W] = chan[c];
    assign level[c] = chan[c] & ext_i[c*CH_W +: CH_W];
  end

  nio_in_sampler #(.CH_N(CH_N), .CH_W(CH_W)) u_smp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (in_en),
    .issue_sel_i (chan_sel_i),
    .issue_dst_i (dst_sel_i),
    .sample_i    (sample_i),
    .level_i     (level),
    .rd_data_o   (rd_data_o),
    .acc_we_o    (acc_we_o),
    .b_we_o      (b_we_o)
  );

  p_noop_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en || pat_en) |=> $stable(pins_o));

  p_read_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_o || b_we_o) |-> ((rd_data_o & ~$past(level[u_smp.sel_q])) == '0));
endmodule

// File: tb/nio_channels_tb_top.sv
module nio_channels_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = '0;
  logic [1:0]  chan_sel = '0;
  logic        src_sel = 1'b0, dst_sel = 1'b0;
  logic [3:0]  acc = '0, breg = '0;
  logic [7:0]  pat = '0;
  logic        sample = 1'b0;
  logic [15:0] ext = '1;
  logic [15:0] pins;
  logic [3:0]  rd_data;
  logic        acc_we, b_we;

  int n_tests = 0, n_fail = 0;
  logic [15:0] exp_pins;

  always #2.5 clk = ~clk;

  nio_channels dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_kind_i(op_kind),
    .chan_sel_i(chan_sel), .src_sel_i(src_sel), .dst_sel_i(dst_sel),
    .acc_i(acc), .breg_i(breg), .pat_i(pat), .sample_i(sample), .ext_i(ext),
    .pins_o(pins), .rd_data_o(rd_data), .acc_we_o(acc_we), .b_we_o(b_we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, one edge, release at next negedge, then look
  task automatic op(input logic [1:0] k, input logic [1:0] ch, input logic s, input logic d);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; chan_sel = ch; src_sel = s; dst_sel = d;
    @(negedge clk);
    op_valid = 1'b0;
    #1;
  endtask

  task automatic strobe();
    @(negedge clk);
    sample = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 pins", pins, 16'hFFFF);
    chk("R1 we", {acc_we, b_we}, 0);
    chk("R1 rd", rd_data, 0);
  endtask

  task automatic t_out();
    acc = 4'h5; breg = 4'hA;
    op(2'd0, 2'd1, 1'b0, 1'b0);
    exp_pins[7:4] = 4'h5;
    chk("R2 acc to ch1", pins, exp_pins);
    op(2'd0, 2'd0, 1'b1, 1'b0);
    exp_pins[3:0] = 4'hA;
    chk("R3 b to ch0", pins, exp_pins);
  endtask

  task automatic t_pattern();
    pat = 8'h3C;
    op(2'd1, 2'd0, 1'b0, 1'b0);
    exp_pins[15:8] = 8'h3C;
    chk("R4 pattern ch3/ch2, ch0/1 kept", pins, exp_pins);
  endtask

  task automatic t_ignore();
    acc = 4'h0; pat = 8'h00;
    op(2'd3, 2'd2, 1'b0, 1'b0);
    chk("R9 reserved kind", pins, exp_pins);
    @(negedge clk);
    op_kind = 2'd0; chan_sel = 2'd3;
    @(negedge clk); #1;
    chk("R9 valid low", pins, exp_pins);
  endtask

  task automatic t_input();
    // ch2 holds C; ext pulls bit1 low -> C & D = C
    ext = 16'hFFFF; ext[9] = 1'b0;
    op(2'd2, 2'd2, 1'b0, 1'b1);
    chk("R10 input keeps regs", pins, exp_pins);
    chk("R5 no early load", {acc_we, b_we}, 0);
    strobe();
    chk("R5 b load", {acc_we, b_we}, 2'b01);
    chk("R6 ch2 masked", rd_data, 4'hC);
    @(negedge clk); sample = 1'b0;
    @(posedge clk); #1;
    chk("R5 pulse one cycle", {acc_we, b_we}, 0);
    chk("R7 held", rd_data, 4'hC);
    // R8: strobe with nothing pending
    strobe();
    chk("R8 no load", {acc_we, b_we}, 0);
    chk("R8 rd kept", rd_data, 4'hC);
    @(negedge clk); sample = 1'b0;
    // write F to ch1, read with ext pulling bits 6,4 low -> A, into acc
    acc = 4'hF;
    op(2'd0, 2'd1, 1'b0, 1'b0);
    exp_pins[7:4] = 4'hF;
    ext = 16'hFFFF; ext[6] = 1'b0; ext[4] = 1'b0;
    op(2'd2, 2'd1, 1'b0, 1'b0);
    strobe();
    chk("R5 acc load", {acc_we, b_we}, 2'b10);
    chk("R6 released ch1", rd_data, 4'hA);
    @(negedge clk); sample = 1'b0; ext = 16'hFFFF;
    // ch0 = A read with ext all high -> A (register masks)
    op(2'd2, 2'd0, 1'b0, 1'b0);
    strobe();
    chk("R6 reg zero bits read low", rd_data, 4'hA);
    @(negedge clk); sample = 1'b0;
  endtask

  initial begin
    exp_pins = 16'hFFFF;
    #12 rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_out();
    t_pattern();
    t_ignore();
    t_input();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule